// File: doc/BRIEF.md
# Load Switch Protection Controller

This block supervises four high-side load switches. Each channel receives a command enable, a digitised "output is on" sense bit and a raw over-current comparator bit. From these it produces a gate-drive request for its switch. The channels run independently of one another; only the fault indication is shared.

An over-current event does not cut the switch at once. The comparator bit is first brought into the clock domain, and its rising edge starts a hold-off timer. While the hold-off runs, the drive keeps following the enable. When the hold-off expires it starts a back-off timer, and the switch is held off for that window. When the back-off ends, the switch turns on again if it is still enabled, which gives automatic retry. Neither timer restarts while it is already running.

Each channel also compares its drive request with the sensed output. A disagreement is counted as a fault only once it has lasted a set number of cycles, which lets the output settle after the drive changes. All channel faults combine into one active-low fault line, in the same way as a shared open-drain wire.

Top module: `load_guard_ctrl`

## Requirements
- R1: When its back-off timer is idle, `gate_req[i]` equals `en_cmd[i]` in the same cycle. A channel's drive never depends on another channel's inputs or timers.
- R2: `oc_raw[i]` passes through two flip-flops and is detected on its rising edge. If it goes high just before clock edge k, the hold-off timer is active from edge k+2 onward.
- R3: The hold-off timer runs for exactly HOLD_CYC cycles. A new rising edge of the over-current input while it runs does not restart or extend it. During hold-off, `gate_req[i]` still follows `en_cmd[i]`.
- R4: The back-off timer starts on the edge where hold-off ends and runs for exactly BACKOFF_CYC cycles. While it runs, `gate_req[i]` is 0 whatever `en_cmd[i]` is.
- R5: When back-off ends, `gate_req[i]` returns to `en_cmd[i]`. It stays 0 if the enable has dropped in the meantime.
- R6: `oc_ok[i]` is 1 only when neither timer of channel i is running.
- R7: The mismatch term is `gate_req[i] XOR out_sense[i]`, so it covers both "on when it should be off" and "off when it should be on". It becomes a fault only after it has held on SETTLE_CYC consecutive edges with no change in `gate_req[i]`. A change in the drive, or the mismatch going away, restarts the count. If a mismatch first appears without a drive change, the fault shows SETTLE_CYC cycles later. If it appears together with a drive change, the fault shows SETTLE_CYC+1 cycles later.
- R8: A channel is faulted when its qualified mismatch is set or either of its timers is running. `fault_n` is 0 when any channel is faulted and 1 otherwise.
- R9: A synchronous active-high `rst` clears both timers, the synchroniser stages and the mismatch qualifiers. After reset, `fault_n`=1 and `oc_ok` is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_cmd | input | NUM_CH | Command enable per channel |
| out_sense | input | NUM_CH | Digitised output-on sense per channel |
| oc_raw | input | NUM_CH | Asynchronous over-current comparator per channel |
| gate_req | output | NUM_CH | Gate-drive request per channel |
| oc_ok | output | NUM_CH | High when neither timer of the channel runs |
| fault_n | output | 1 | Shared fault, active low |

## Verification
The bench builds the block with four channels, HOLD_CYC=5, BACKOFF_CYC=8 and SETTLE_CYC=3. These short windows let it check each timer boundary exactly, one cycle before and one cycle after, within a few dozen cycles. They also leave room to fire a second over-current pulse inside the hold-off. The small settle count separates the two mismatch cases: a mismatch with no drive change, and a mismatch that arrives together with a drive change. The bench also resets the block in the middle of a back-off window.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  typedef struct packed {
    logic holdoff;
    logic backoff;
    logic mismatch;
  } ch_stat_t;
endpackage

// File: rtl/lgc_edge_sync.sv
module lgc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lgc_oneshot.sv
module lgc_oneshot #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;
  logic          act_q;

  // Start requests are honoured only from idle: no retrigger.
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!act_q) begin
      if (start) begin
        act_q <= 1'b1;
        cnt_q <= CW'(LEN - 1);
      end
    end else if (cnt_q == '0) begin
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = act_q;
  assign done   = act_q && (cnt_q == '0);
endmodule

// File: rtl/lgc_mismatch_qual.sv
module lgc_mismatch_qual #(
  parameter int SETTLE = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic drive,
  input  logic sense,
  output logic flag
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q;
  logic          drive_q;
  logic          raw_mm;

  assign raw_mm = drive ^ sense;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= drive;
      if ((drive != drive_q) || !raw_mm) begin
        cnt_q <= '0;
      end else if (cnt_q != CW'(SETTLE)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flag = (cnt_q == CW'(SETTLE));
endmodule

// File: rtl/lgc_channel.sv
module lgc_channel
  import lgc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 5,
  parameter int BACKOFF_CYC = 8,
  parameter int SETTLE_CYC  = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     sense,
  input  logic     oc_in,
  output logic     drive,
  output ch_stat_t stat
);
  logic oc_rise;
  logic hold_act, hold_done;
  logic back_act, back_done;
  logic mm_flag;

  lgc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(oc_in), .rise(oc_rise)
  );

  lgc_oneshot #(.LEN(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .start(oc_rise),
    .active(hold_act), .done(hold_done)
  );

  lgc_oneshot #(.LEN(BACKOFF_CYC)) u_back (
    .clk(clk), .rst(rst), .start(hold_done),
    .active(back_act), .done(back_done)
  );

  // Only the back-off window gates the switch; hold-off leaves it alone.
  assign drive = en & ~back_act;

  lgc_mismatch_qual #(.SETTLE(SETTLE_CYC)) u_mm (
    .clk(clk), .rst(rst), .drive(drive), .sense(sense), .flag(mm_flag)
  );

  always_comb begin
    stat          = '0;
    stat.holdoff  = hold_act;
    stat.backoff  = back_act;
    stat.mismatch = mm_flag;
  end

  logic unused_done;
  assign unused_done = back_done;
endmodule

// File: rtl/load_guard_ctrl.sv
module load_guard_ctrl
  import lgc_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 5,
  parameter int BACKOFF_CYC = 8,
  parameter int SETTLE_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] en_cmd,
  input  logic [NUM_CH-1:0] out_sense,
  input  logic [NUM_CH-1:0] oc_raw,
  output logic [NUM_CH-1:0] gate_req,
  output logic [NUM_CH-1:0] oc_ok,
  output logic              fault_n
);
  ch_stat_t          stat [NUM_CH];
  logic [NUM_CH-1:0] hold_vec;
  logic [NUM_CH-1:0] back_vec;
  logic [NUM_CH-1:0] ch_fault;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    lgc_channel #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_CYC(HOLD_CYC),
      .BACKOFF_CYC(BACKOFF_CYC),
      .SETTLE_CYC(SETTLE_CYC)
    ) u_ch (
      .clk(clk), .rst(rst),
      .en(en_cmd[i]), .sense(out_sense[i]), .oc_in(oc_raw[i]),
      .drive(gate_req[i]), .stat(stat[i])
    );
    assign hold_vec[i] = stat[i].holdoff;
    assign back_vec[i] = stat[i].backoff;
    assign oc_ok[i]    = ~(stat[i].holdoff | stat[i].backoff);
    assign ch_fault[i] = stat[i].mismatch | stat[i].holdoff | stat[i].backoff;
  end

  // Shared line: any faulted channel pulls it low.
  assign fault_n = ~(|ch_fault);
endmodule

// File: rtl/load_guard_ctrl_chk.sv
module load_guard_ctrl_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] en_cmd,
  input logic [NUM_CH-1:0] gate_req,
  input logic [NUM_CH-1:0] oc_ok,
  input logic              fault_n,
  input logic [NUM_CH-1:0] hold_vec,
  input logic [NUM_CH-1:0] back_vec
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_p
    p_backoff_off_r4: assert property (@(posedge clk) disable iff (rst)
      back_vec[i] |-> !gate_req[i]);
    p_chain_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(back_vec[i]) |-> ($past(hold_vec[i]) && !hold_vec[i]));
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(back_vec[i]) && en_cmd[i]) |-> gate_req[i]);
    p_idle_follow_r1: assert property (@(posedge clk) disable iff (rst)
      !back_vec[i] |-> (gate_req[i] == en_cmd[i]));
    p_status_fault_r8: assert property (@(posedge clk) disable iff (rst)
      !oc_ok[i] |-> !fault_n);
  end

  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (fault_n && (&oc_ok)));
endmodule

bind load_guard_ctrl load_guard_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .en_cmd(en_cmd), .gate_req(gate_req),
  .oc_ok(oc_ok), .fault_n(fault_n), .hold_vec(hold_vec), .back_vec(back_vec)
);

// File: tb/load_guard_ctrl_tb.sv
module load_guard_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int HOLD = 5;
  localparam int BACK = 8;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] en_cmd = '0;
  logic [NCH-1:0] oc_raw = '0;
  logic [NCH-1:0] inject = '0;
  logic [NCH-1:0] out_sense;
  logic [NCH-1:0] gate_req;
  logic [NCH-1:0] oc_ok;
  logic           fault_n;

  // Plant: output follows the drive unless a fault is injected.
  assign out_sense = gate_req ^ inject;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_guard_ctrl #(
    .NUM_CH(NCH), .SYNC_STAGES(2), .HOLD_CYC(HOLD),
    .BACKOFF_CYC(BACK), .SETTLE_CYC(SETTLE)
  ) u_dut (
    .clk(clk), .rst(rst), .en_cmd(en_cmd), .out_sense(out_sense),
    .oc_raw(oc_raw), .gate_req(gate_req), .oc_ok(oc_ok), .fault_n(fault_n)
  );

  typedef struct {
    int    due;
    int    kind;   // 0 gate_req, 1 oc_ok, 2 fault_n
    int    ch;
    bit    exp;
    string req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int dly, input int kind, input int ch,
                           input bit exp, input string req);
    item_t it;
    int pos;
    it.due = cyc + dly; it.kind = kind; it.ch = ch; it.exp = exp; it.req = req;
    pos = sb.size();
    for (int k = 0; k < sb.size(); k++) begin
      if (sb[k].due > it.due) begin pos = k; break; end
    end
    sb.insert(pos, it);
  endtask

  // Monitor: sample away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      bit act;
      it = sb.pop_front();
      case (it.kind)
        0: act = gate_req[it.ch];
        1: act = oc_ok[it.ch];
        default: act = fault_n;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d ch=%0d cyc=%0d actual=%0b expected=%0b",
                 it.req, it.kind, it.ch, cyc, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R9 reset state
    expect_at(1, 2, 0, 1'b1, "R9");
    for (int c = 0; c < NCH; c++) expect_at(1, 1, c, 1'b1, "R9");
    expect_at(1, 0, 0, 1'b0, "R9");
    drain();

    // R1 direct follow, several patterns
    en_cmd = 4'b1010;
    expect_at(1, 0, 1, 1'b1, "R1"); expect_at(1, 0, 0, 1'b0, "R1");
    tick(2);
    en_cmd = 4'b0101;
    expect_at(1, 0, 0, 1'b1, "R1"); expect_at(1, 0, 3, 1'b0, "R1");
    expect_at(SETTLE + 3, 2, 0, 1'b1, "R8");
    drain();

    // R2/R3/R4/R5 over-current on channel 2 with retrigger inside hold-off
    en_cmd = 4'b1111;
    tick(2);
    oc_raw[2] = 1'b1;
    expect_at(2, 1, 2, 1'b1, "R2");
    expect_at(3, 1, 2, 1'b0, "R2");
    expect_at(3, 0, 2, 1'b1, "R3");
    expect_at(3, 2, 0, 1'b0, "R8");
    expect_at(2 + HOLD, 0, 2, 1'b1, "R3");
    expect_at(3 + HOLD, 0, 2, 1'b0, "R4");
    expect_at(3 + HOLD, 0, 0, 1'b1, "R1");
    expect_at(2 + HOLD + BACK, 0, 2, 1'b0, "R4");
    expect_at(2 + HOLD + BACK, 1, 2, 1'b0, "R6");
    expect_at(3 + HOLD + BACK, 0, 2, 1'b1, "R5");
    expect_at(3 + HOLD + BACK, 1, 2, 1'b1, "R6");
    expect_at(3 + HOLD + BACK, 2, 0, 1'b1, "R8");
    tick(2); oc_raw[2] = 1'b0;
    tick(2); oc_raw[2] = 1'b1;   // rising edge during hold-off
    tick(2); oc_raw[2] = 1'b0;
    drain();

    // R5 enable dropped during back-off on channel 3
    oc_raw[3] = 1'b1;
    tick(1); oc_raw[3] = 1'b0;
    tick(3 + HOLD);
    en_cmd[3] = 1'b0;
    expect_at(BACK, 0, 3, 1'b0, "R5");
    expect_at(BACK, 1, 3, 1'b1, "R6");
    drain();
    en_cmd[3] = 1'b1;
    expect_at(1, 0, 3, 1'b1, "R5");
    drain();
    tick(SETTLE + 2);

    // R7 off-when-on mismatch, no drive change
    inject[1] = 1'b1;
    expect_at(SETTLE - 1, 2, 0, 1'b1, "R7");
    expect_at(SETTLE, 2, 0, 1'b0, "R7");
    drain();
    inject[1] = 1'b0;
    expect_at(1, 2, 0, 1'b1, "R7");
    drain();

    // R7 on-when-off mismatch arriving with a drive change
    en_cmd[0] = 1'b0;
    inject[0] = 1'b1;
    expect_at(SETTLE, 2, 0, 1'b1, "R7");
    expect_at(SETTLE + 1, 2, 0, 1'b0, "R7");
    drain();
    inject[0] = 1'b0;
    en_cmd[0] = 1'b1;
    tick(SETTLE + 2);
    expect_at(1, 2, 0, 1'b1, "R7");
    drain();

    // R9 reset in the middle of back-off on channel 1
    oc_raw[1] = 1'b1;
    tick(1); oc_raw[1] = 1'b0;
    expect_at(4 + HOLD, 0, 1, 1'b0, "R4");
    drain();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    expect_at(1, 0, 1, 1'b1, "R9");
    expect_at(1, 1, 1, 1'b1, "R9");
    expect_at(1, 2, 0, 1'b1, "R9");
    drain();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule